// File: doc/BRIEF.md
# Listen-Before-Transmit Access Controller

This block decides when a packet waiting in the transmit path may start going out on air. When the transmit path raises a request, the controller uses the two access-mode bits to choose one of four policies:

- send at once;
- wait out a deterministic polling slot, with no look at the channel;
- switch the receiver on, let it settle, and send only when the channel is quiet;
- the same quiet-channel check, but a busy channel leads to a random back-off of whole milliseconds before the next look.

When the chosen policy allows, the controller emits a single-cycle go strobe. It then holds off all further requests until the transmit path reports the packet finished.

Timing runs on a tick of 50 µs, made by dividing the clock by `TICK_DIV`. The slot delay, in ticks, is `slot × (preamble + 6·bytes + 6·turnaround + 10)`. Here the preamble count is in 50 µs cycles and the turnaround is in 100 µs units, so this sum is the per-slot time expressed in 50 µs steps. The receiver settle time is given in 100 µs units and counts as two ticks per unit. The back-off draw comes from a free-running 16-bit LFSR and is masked to the width chosen by the exponent. Each millisecond of back-off lasts 20 ticks.

Top module: `lbt_access_ctrl`

## Requirements
- R1: After reset, `tx_go` and `rx_en` are both low and the controller is idle.
- R2: With `access_mode` = 2'b00, `tx_go` goes high in the cycle after the edge that samples `tx_req` high, and `rx_en` stays low throughout.
- R3: With `access_mode` = 2'b01, `tx_go` goes high `slot_num × (preamble_cnt + 6·pkt_bytes + 6·turnaround + 10) × TICK_DIV + 1` cycles after the cycle in which the request is accepted, and `rx_en` stays low. A slot number of 0 gives the minimum delay.
- R4: With `access_mode[1]` = 1, `rx_en` rises when the request is accepted and stays high for `2 × rx_settle` ticks before the channel is first examined. Channel busy is ignored during that time.
- R5: With `access_mode` = 2'b10, `tx_go` is raised only on an edge at which `chan_busy` is low. While the channel is busy, the controller keeps `rx_en` high and keeps checking.
- R6: With `access_mode` = 2'b11, a busy channel at the check drops `rx_en` and starts a back-off of r ms, where 0 ≤ r ≤ 2^(`backoff_exp`+1) − 1. After the back-off, the receiver settles again and the channel is checked again.
- R7: A `chan_busy` level during the back-off wait neither restarts nor lengthens that wait.
- R8: `tx_go` lasts exactly one cycle. After it, `tx_req` is ignored and `rx_en` stays low until `tx_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | A packet is queued and wants the channel |
| tx_done | input | 1 | The granted packet has finished transmitting |
| chan_busy | input | 1 | Receiver reports preamble or data on the channel |
| access_mode | input | 2 | bit1 = listen first, bit0 = delay (slot or random) |
| slot_num | input | SLOT_W | Polling slot index, 0 to 255 |
| preamble_cnt | input | PRE_W | Preamble length in 50 µs cycles |
| pkt_bytes | input | LEN_W | Packet length in bytes |
| turnaround | input | TURN_W | Transmit/receive turnaround in 100 µs units |
| rx_settle | input | SETTLE_W | Receiver settle time in 100 µs units |
| backoff_exp | input | BO_W | Back-off exponent n, range 0 to 2^(n+1) − 1 ms |
| rx_en | output | 1 | Receiver enable for channel sensing |
| tx_go | output | 1 | One-cycle strobe: start transmission now |

## Verification
The assertions assume that the access mode and timing inputs stay unchanged from the accepted request until `tx_done`. They also assume that `tx_done` arrives only after a grant. The bench drives all configuration fields at a falling edge before raising the request, and holds them until the acknowledge. It raises `tx_done` only after it has seen `tx_go`. Channel-busy pulses are placed only where the requirements leave their effect defined: during settling, during back-off, or at a known check edge.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    typedef enum logic [1:0] {
        ACC_NOW           = 2'b00,
        ACC_SLOT          = 2'b01,
        ACC_CLEAR         = 2'b10,
        ACC_CLEAR_BACKOFF = 2'b11
    } lbt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETTLE,
        ST_SENSE,
        ST_BACKOFF,
        ST_GRANT,
        ST_HOLD
    } lbt_state_e;

    localparam int TICKS_PER_MS     = 20;
    localparam int TICKS_PER_SETTLE = 2;

endpackage

// File: rtl/lbt_tick.sv
module lbt_tick #(
    parameter int DIV = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] presc_d, presc_q;

    assign tick = (presc_q == PW'(DIV - 1));

    always_comb begin
        if (clr || tick) presc_d = '0;
        else             presc_d = presc_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end
endmodule

// File: rtl/lbt_lfsr.sv
module lbt_lfsr #(
    parameter int          OUT_W = 8,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    localparam logic [15:0] TAPS = 16'hB400;

    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/lbt_slot_calc.sv
module lbt_slot_calc #(
    parameter int SLOT_W = 8,
    parameter int PRE_W  = 8,
    parameter int LEN_W  = 5,
    parameter int TURN_W = 8,
    parameter int CNT_W  = 20
) (
    input  logic [SLOT_W-1:0] slot_num,
    input  logic [PRE_W-1:0]  preamble_cnt,
    input  logic [LEN_W-1:0]  pkt_bytes,
    input  logic [TURN_W-1:0] turnaround,
    output logic [CNT_W-1:0]  delay_ticks
);
    localparam logic [CNT_W-1:0] BYTE_TICKS  = CNT_W'(6);
    localparam logic [CNT_W-1:0] TURN_TICKS  = CNT_W'(6);
    localparam logic [CNT_W-1:0] GUARD_TICKS = CNT_W'(10);

    logic [CNT_W-1:0] unit_ticks;

    always_comb begin
        unit_ticks  = CNT_W'(preamble_cnt)
                    + CNT_W'(pkt_bytes)  * BYTE_TICKS
                    + CNT_W'(turnaround) * TURN_TICKS
                    + GUARD_TICKS;
        delay_ticks = CNT_W'(slot_num) * unit_ticks;
    end
endmodule

// File: rtl/lbt_access_ctrl.sv
module lbt_access_ctrl
    import lbt_pkg::*;
#(
    parameter int          TICK_DIV  = 2500,
    parameter int          SLOT_W    = 8,
    parameter int          PRE_W     = 8,
    parameter int          LEN_W     = 5,
    parameter int          TURN_W    = 8,
    parameter int          SETTLE_W  = 8,
    parameter int          BO_W      = 3,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_req,
    input  logic                tx_done,
    input  logic                chan_busy,
    input  logic [1:0]          access_mode,
    input  logic [SLOT_W-1:0]   slot_num,
    input  logic [PRE_W-1:0]    preamble_cnt,
    input  logic [LEN_W-1:0]    pkt_bytes,
    input  logic [TURN_W-1:0]   turnaround,
    input  logic [SETTLE_W-1:0] rx_settle,
    input  logic [BO_W-1:0]     backoff_exp,
    output logic                rx_en,
    output logic                tx_go
);
    localparam int UNIT_MAX = (2**PRE_W - 1) + 6 * (2**LEN_W - 1)
                            + 6 * (2**TURN_W - 1) + 10;
    localparam int CNT_W    = $clog2((2**SLOT_W - 1) * UNIT_MAX + 1);
    localparam int RAND_W   = 2**BO_W;

    typedef struct packed {
        lbt_state_e       state;
        lbt_mode_e        mode;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t r_d, r_q;

    lbt_state_e       state_q;
    lbt_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    assign state_q = r_q.state;
    assign mode_q  = r_q.mode;
    assign cnt_q   = r_q.cnt;

    logic              tick, tick_clr;
    logic [CNT_W-1:0]  slot_ticks, settle_ticks, backoff_ticks;
    logic [RAND_W-1:0] rnd, rnd_mask;

    lbt_tick #(.DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
    );

    lbt_lfsr #(.OUT_W(RAND_W), .SEED(LFSR_SEED)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    lbt_slot_calc #(
        .SLOT_W(SLOT_W), .PRE_W(PRE_W), .LEN_W(LEN_W),
        .TURN_W(TURN_W), .CNT_W(CNT_W)
    ) i_slot (
        .slot_num(slot_num), .preamble_cnt(preamble_cnt),
        .pkt_bytes(pkt_bytes), .turnaround(turnaround),
        .delay_ticks(slot_ticks)
    );

    always_comb begin
        rnd_mask      = RAND_W'((2 << backoff_exp) - 1);
        settle_ticks  = CNT_W'(rx_settle) * CNT_W'(TICKS_PER_SETTLE);
        backoff_ticks = CNT_W'(rnd & rnd_mask) * CNT_W'(TICKS_PER_MS);
    end

    always_comb begin
        r_d      = r_q;
        tick_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_req) begin
                    r_d.mode = lbt_mode_e'(access_mode);
                    tick_clr = 1'b1;
                    unique case (lbt_mode_e'(access_mode))
                        ACC_NOW:  r_d.state = ST_GRANT;
                        ACC_SLOT: begin
                            r_d.state = ST_WAIT;
                            r_d.cnt   = slot_ticks;
                        end
                        default: begin
                            r_d.state = ST_SETTLE;
                            r_d.cnt   = settle_ticks;
                        end
                    endcase
                end
            end
            ST_WAIT, ST_SETTLE, ST_BACKOFF: begin
                if (cnt_q == '0) begin
                    if (state_q == ST_WAIT) begin
                        r_d.state = ST_GRANT;
                    end else if (state_q == ST_SETTLE) begin
                        r_d.state = ST_SENSE;
                    end else begin
                        r_d.state = ST_SETTLE;
                        r_d.cnt   = settle_ticks;
                        tick_clr  = 1'b1;
                    end
                end else if (tick) begin
                    r_d.cnt = cnt_q - CNT_W'(1);
                end
            end
            ST_SENSE: begin
                if (!chan_busy) begin
                    r_d.state = ST_GRANT;
                end else if (mode_q == ACC_CLEAR_BACKOFF) begin
                    r_d.state = ST_BACKOFF;
                    r_d.cnt   = backoff_ticks;
                    tick_clr  = 1'b1;
                end
            end
            ST_GRANT: r_d.state = ST_HOLD;
            ST_HOLD:  if (tx_done) r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.mode  <= ACC_NOW;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_go = (state_q == ST_GRANT);
    assign rx_en = (state_q == ST_SETTLE) || (state_q == ST_SENSE);

endmodule

// File: rtl/lbt_access_checker.sv
module lbt_access_checker
    import lbt_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int BO_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_go,
    input logic             rx_en,
    input logic             chan_busy,
    input logic [BO_W-1:0]  backoff_exp,
    input lbt_state_e       state_q,
    input lbt_mode_e        mode_q,
    input logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] bo_limit;
    assign bo_limit = CNT_W'(((2 << backoff_exp) - 1) * TICKS_PER_MS);

    assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> !tx_go);

    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (!tx_go && !rx_en));

    assert_rx_only_listen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> mode_q[1]);

    assert_grant_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && mode_q[1]) |-> $past(!chan_busy));

    assert_backoff_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF && $past(state_q) != ST_BACKOFF) |-> (cnt_q <= bo_limit));

    assert_backoff_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF && $past(state_q) == ST_BACKOFF) |-> (cnt_q <= $past(cnt_q)));

    assert_backoff_rx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF) |-> !rx_en);
endmodule

bind lbt_access_ctrl lbt_access_checker #(.CNT_W(CNT_W), .BO_W(BO_W)) i_checker (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .rx_en(rx_en),
    .chan_busy(chan_busy), .backoff_exp(backoff_exp),
    .state_q(state_q), .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/test_lbt_access_ctrl.sv
module test_lbt_access_ctrl;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_req = 1'b0, tx_done = 1'b0, chan_busy = 1'b0;
    logic [1:0] access_mode = 2'b00;
    logic [7:0] slot_num = '0, preamble_cnt = '0, turnaround = '0, rx_settle = '0;
    logic [4:0] pkt_bytes = '0;
    logic [2:0] backoff_exp = '0;
    logic       rx_en, tx_go;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lbt_access_ctrl #(.TICK_DIV(DIV)) i_lbt_access_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_done(tx_done),
        .chan_busy(chan_busy), .access_mode(access_mode), .slot_num(slot_num),
        .preamble_cnt(preamble_cnt), .pkt_bytes(pkt_bytes), .turnaround(turnaround),
        .rx_settle(rx_settle), .backoff_exp(backoff_exp),
        .rx_en(rx_en), .tx_go(tx_go)
    );

    // {mode, slot, preamble, bytes, turnaround, settle}
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 8'd0, 8'd0,  5'd0, 8'd0, 8'd0},
        {2'd0, 8'd9, 8'd9,  5'd9, 8'd9, 8'd9},
        {2'd1, 8'd0, 8'd50, 5'd4, 8'd3, 8'd0},
        {2'd1, 8'd1, 8'd1,  5'd1, 8'd1, 8'd0},
        {2'd1, 8'd2, 8'd10, 5'd3, 8'd2, 8'd0},
        {2'd2, 8'd0, 8'd0,  5'd0, 8'd0, 8'd1},
        {2'd2, 8'd0, 8'd0,  5'd0, 8'd0, 8'd0},
        {2'd3, 8'd0, 8'd0,  5'd0, 8'd0, 8'd3}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_latency(input logic [38:0] v);
        int m, sl, pr, by, tu, se;
        m  = int'(v[38:37]); sl = int'(v[36:29]); pr = int'(v[28:21]);
        by = int'(v[20:16]); tu = int'(v[15:8]);  se = int'(v[7:0]);
        if (m == 0)      return 1;
        else if (m == 1) return sl * (pr + 6 * by + 6 * tu + 10) * DIV + 2;
        else             return 2 * se * DIV + 3;
    endfunction

    // Raise request at a falling edge, count rising edges until tx_go.
    task automatic request_and_wait(output int edges, output bit saw_rx);
        edges  = 0;
        saw_rx = 1'b0;
        tx_req = 1'b1;
        while (edges < 5000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (rx_en) saw_rx = 1'b1;
            if (tx_go) break;
        end
        tx_req = 1'b0;
    endtask

    task automatic finish_access();
        @(negedge clk);
        check(!tx_go, "R8", "tx_go second cycle", int'(tx_go), 0);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int  lat;
        bit  srx;
        repeat (3) @(negedge clk);
        check(!tx_go && !rx_en, "R1", "outputs in reset", int'({tx_go, rx_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_go && !rx_en, "R1", "outputs after reset", int'({tx_go, rx_en}), 0);

        // Table walk: R2, R3, R4
        for (int i = 0; i < NV; i++) begin
            access_mode  = VEC[i][38:37];
            slot_num     = VEC[i][36:29];
            preamble_cnt = VEC[i][28:21];
            pkt_bytes    = VEC[i][20:16];
            turnaround   = VEC[i][15:8];
            rx_settle    = VEC[i][7:0];
            chan_busy    = 1'b0;
            request_and_wait(lat, srx);
            if (access_mode == 2'd0) begin
                check(lat == expect_latency(VEC[i]), "R2", "immediate latency", lat, expect_latency(VEC[i]));
                check(!srx, "R2", "rx_en in immediate mode", int'(srx), 0);
            end else if (access_mode == 2'd1) begin
                check(lat == expect_latency(VEC[i]), "R3", "slot latency", lat, expect_latency(VEC[i]));
                check(!srx, "R3", "rx_en in slot mode", int'(srx), 0);
            end else begin
                check(lat == expect_latency(VEC[i]), "R4", "settle latency", lat, expect_latency(VEC[i]));
                check(srx, "R4", "rx_en during settle", int'(srx), 1);
            end
            finish_access();
        end

        // R8: requests ignored until tx_done
        access_mode = 2'd0;
        request_and_wait(lat, srx);
        tx_req = 1'b1;
        begin
            bit extra = 1'b0;
            bit rxs   = 1'b0;
            @(negedge clk);
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (tx_go) extra = 1'b1;
                if (rx_en) rxs = 1'b1;
            end
            check(!extra, "R8", "tx_go while waiting for done", int'(extra), 0);
            check(!rxs, "R8", "rx_en while waiting for done", int'(rxs), 0);
        end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        @(negedge clk);
        check(tx_go, "R8", "new grant after done", int'(tx_go), 1);
        tx_req = 1'b0;
        finish_access();

        // R5: busy channel blocks grant in mode 10
        access_mode = 2'd2;
        rx_settle   = 8'd1;
        chan_busy   = 1'b1;
        tx_req      = 1'b1;
        begin
            bit got = 1'b0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (tx_go) got = 1'b1;
            end
            check(!got, "R5", "grant while busy", int'(got), 0);
            check(rx_en, "R5", "rx_en while busy", int'(rx_en), 1);
        end
        tx_req    = 1'b0;
        chan_busy = 1'b0;
        @(negedge clk);
        check(tx_go, "R5", "grant one edge after clear", int'(tx_go), 1);
        finish_access();

        // R6, R7: back-off in mode 11
        access_mode = 2'd3;
        rx_settle   = 8'd1;
        backoff_exp = 3'd0;
        chan_busy   = 1'b1;
        tx_req      = 1'b1;
        lat = 0;
        for (int k = 0; k < 11; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        tx_req    = 1'b0;
        chan_busy = 1'b0;
        check(!rx_en, "R6", "rx_en during back-off", int'(rx_en), 1'b0);
        begin
            bit busy_at_go = 1'b0;
            bit got        = 1'b0;
            while (lat < 200) begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                chan_busy = (lat >= 13 && lat <= 16);
                if (tx_go) begin
                    got = 1'b1;
                    busy_at_go = chan_busy;
                    break;
                end
            end
            chan_busy = 1'b0;
            check(got && lat >= 22 && lat <= 102, "R6", "back-off grant edge", lat, 102);
            check(got && !busy_at_go, "R7", "busy pulse in wait ignored, grant on clear", int'(busy_at_go), 0);
        end
        finish_access();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule